// File: doc/BRIEF.md
# Bus-Connection Activity LED Driver

This block keeps a single status flag that says whether the controller currently holds a connection on the parallel peripheral bus, either as initiator or as target. The bus phase logic sends it one-cycle event pulses. Three kinds of event set the flag: an outgoing selection that completed, a successful answer to an incoming selection or reselection, and a win of arbitration while the engine runs in low-level mode. A disconnect or bus-free event clears it. The flag is shown at bit 3 of an 8-bit interrupt-status fragment.

The block also owns the output stage of a five-pin general-purpose port. By default every pin carries the level and direction that software programmed. Pin 0 can instead be handed to hardware so that it lights an activity LED while a connection exists. The handover is gated by two bits of the pin control word and by the busy flag of the configuration autoload engine. All pin outputs are registered, so the LED level never glitches when ownership changes.

Top module: `bus_conn_led`

## Requirements
- R1: During and straight after reset, the connected flag is 0, every pin output level is 0 and every pin output enable is 0.
- R2: A pulse on `sel_done_i` sets the connected flag at the next clock edge.
- R3: A pulse on `tgt_resp_i` sets the connected flag at the next clock edge.
- R4: A pulse on `arb_win_ll_i` sets the connected flag at the next clock edge.
- R5: A pulse on `bus_free_i` clears the connected flag at the next clock edge. If any set event comes in the same cycle, the flag is set instead.
- R6: With no event pulse, the connected flag holds its value.
- R7: `istat_o[3]` equals the connected flag at all times, and the other seven bits of `istat_o` are 0.
- R8: Hardware LED mode is active when `pin_ctl_i[5]` is 1, `pin_ctl_i[6]` (fetch enable) is 0 and `autoload_busy_i` is 0. In a cycle where this holds, the following edge loads `gpio_oe_o[0]` with 1 and loads `gpio_do_o[0]` with the value the connected flag had before that edge.
- R9: In a cycle where any of the three R8 conditions fails, the following edge loads `gpio_do_o[0]` with `sw_do_i[0]` and loads `gpio_oe_o[0]` with `pin_ctl_i[0]`.
- R10: For pins 1 to 4, each edge loads `gpio_do_o[k]` with `sw_do_i[k]` and loads `gpio_oe_o[k]` with `pin_ctl_i[k]`. The LED mode has no effect on these pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_done_i | input | 1 | Pulse: selection as initiator completed |
| tgt_resp_i | input | 1 | Pulse: responded to a selection or reselection as target |
| arb_win_ll_i | input | 1 | Pulse: arbitration won in low-level mode |
| bus_free_i | input | 1 | Pulse: disconnect or bus-free seen |
| pin_ctl_i | input | 7 | Pin control word: [4:0] software output enables, [5] LED mode request, [6] fetch enable |
| autoload_busy_i | input | 1 | Configuration autoload from serial memory in progress |
| sw_do_i | input | 5 | Software output levels for the pins |
| istat_o | output | 8 | Interrupt-status fragment; bit 3 is the connected flag |
| conn_o | output | 1 | Connected flag |
| gpio_do_o | output | 5 | Registered pin output levels |
| gpio_oe_o | output | 5 | Registered pin output enables |

## Verification
The bench drives set and clear pulses in the same cycle. A design that gave priority to the clear would drop the LED just as a new connection starts. The bench also toggles each of the three gate conditions on its own, including autoload busy while both control bits already allow LED mode. A gate that ignored one condition would take pin 0 away from software during an autoload, or while fetch enable is set. Pin 0 is sampled on the edge after each change of the gate and of the flag. An unregistered path, or a path that reads the flag after its update, shows up as a level that arrives one cycle early. Random software values on pins 1 to 4 expose any leak of the LED mode onto other pins.

// File: rtl/bus_conn_led_pkg.sv
package bus_conn_led_pkg;
  localparam int unsigned GPIO_N    = 5;
  localparam int unsigned CTL_W     = 7;
  localparam int unsigned ISTAT_W   = 8;
  localparam int unsigned CONN_POS  = 3;
  localparam int unsigned LEDREQ_POS = 5;
  localparam int unsigned FETCH_POS = 6;
  localparam int unsigned LED_PIN   = 0;

  typedef struct packed {
    logic sel_done;
    logic tgt_resp;
    logic arb_win_ll;
    logic bus_free;
  } conn_evt_t;
endpackage

// File: rtl/conn_tracker.sv
module conn_tracker
  import bus_conn_led_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  conn_evt_t evt_i,
  output logic      conn_o
);
  logic set_any;
  logic conn_q;

  assign set_any = evt_i.sel_done | evt_i.tgt_resp | evt_i.arb_win_ll;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           conn_q <= 1'b0;
    else if (set_any)      conn_q <= 1'b1;
    else if (evt_i.bus_free) conn_q <= 1'b0;
  end

  assign conn_o = conn_q;

  AST_SEL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.sel_done |=> conn_o); // R2
  AST_TGT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.tgt_resp |=> conn_o); // R3
  AST_ARB_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.arb_win_ll |=> conn_o); // R4
  AST_FREE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.bus_free && !evt_i.sel_done && !evt_i.tgt_resp && !evt_i.arb_win_ll) |=> !conn_o); // R5
  AST_CONN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i.bus_free && !evt_i.sel_done && !evt_i.tgt_resp && !evt_i.arb_win_ll) |=> $stable(conn_o)); // R6
endmodule

// File: rtl/led_gate.sv
module led_gate
  import bus_conn_led_pkg::*;
(
  input  logic [CTL_W-1:0] pin_ctl_i,
  input  logic             autoload_busy_i,
  output logic             hw_own_o
);
  assign hw_own_o = pin_ctl_i[LEDREQ_POS] & ~pin_ctl_i[FETCH_POS] & ~autoload_busy_i;
endmodule

// File: rtl/gpio_out_stage.sv
module gpio_out_stage
  import bus_conn_led_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_own_i,
  input  logic              conn_i,
  input  logic [GPIO_N-1:0] sw_do_i,
  input  logic [GPIO_N-1:0] sw_oe_i,
  output logic [GPIO_N-1:0] do_o,
  output logic [GPIO_N-1:0] oe_o
);
  logic [GPIO_N-1:0] do_q, oe_q;

  for (genvar k = 0; k < GPIO_N; k++) begin : g_pin
    if (k == LED_PIN) begin : g_led
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          do_q[k] <= 1'b0;
          oe_q[k] <= 1'b0;
        end else begin
          do_q[k] <= hw_own_i ? conn_i : sw_do_i[k];
          oe_q[k] <= hw_own_i | sw_oe_i[k];
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          do_q[k] <= 1'b0;
          oe_q[k] <= 1'b0;
        end else begin
          do_q[k] <= sw_do_i[k];
          oe_q[k] <= sw_oe_i[k];
        end
      end
    end
  end

  assign do_o = do_q;
  assign oe_o = oe_q;

  AST_HW_FORCES_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_own_i |=> oe_o[LED_PIN]); // R8
  AST_HW_SHOWS_CONN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_own_i |=> (do_o[LED_PIN] == $past(conn_i))); // R8
  AST_SW_OWNS_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_own_i |=> (do_o[LED_PIN] == $past(sw_do_i[LED_PIN]) && oe_o[LED_PIN] == $past(sw_oe_i[LED_PIN]))); // R9
  AST_OTHERS_SW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (do_o[GPIO_N-1:1] == $past(sw_do_i[GPIO_N-1:1]) && oe_o[GPIO_N-1:1] == $past(sw_oe_i[GPIO_N-1:1]))); // R10
endmodule

// File: rtl/bus_conn_led.sv
module bus_conn_led
  import bus_conn_led_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_done_i,
  input  logic              tgt_resp_i,
  input  logic              arb_win_ll_i,
  input  logic              bus_free_i,
  input  logic [CTL_W-1:0]  pin_ctl_i,
  input  logic              autoload_busy_i,
  input  logic [GPIO_N-1:0] sw_do_i,
  output logic [ISTAT_W-1:0] istat_o,
  output logic              conn_o,
  output logic [GPIO_N-1:0] gpio_do_o,
  output logic [GPIO_N-1:0] gpio_oe_o
);
  conn_evt_t evt;
  logic      conn;
  logic      hw_own;

  assign evt = '{sel_done: sel_done_i, tgt_resp: tgt_resp_i,
                 arb_win_ll: arb_win_ll_i, bus_free: bus_free_i};

  conn_tracker u_trk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .conn_o (conn)
  );

  led_gate u_gate (
    .pin_ctl_i       (pin_ctl_i),
    .autoload_busy_i (autoload_busy_i),
    .hw_own_o        (hw_own)
  );

  gpio_out_stage u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hw_own_i (hw_own),
    .conn_i   (conn),
    .sw_do_i  (sw_do_i),
    .sw_oe_i  (pin_ctl_i[GPIO_N-1:0]),
    .do_o     (gpio_do_o),
    .oe_o     (gpio_oe_o)
  );

  always_comb begin
    istat_o = '0;
    istat_o[CONN_POS] = conn;
  end
  assign conn_o = conn;

  AST_ISTAT_MIRROR: assert property (@(posedge clk_i)
    istat_o == (ISTAT_W'(conn_o) << CONN_POS)); // R7
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!conn_o && gpio_oe_o == '0 && gpio_do_o == '0)); // R1
endmodule

// File: tb/bus_conn_led_tb_top.sv
module bus_conn_led_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND = 3000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_done = 0, tgt_resp = 0, arb_win = 0, bus_free = 0;
  logic [6:0] pin_ctl = '0;
  logic       busy = 0;
  logic [4:0] sw_do = '0;
  logic [7:0] istat;
  logic       conn;
  logic [4:0] gdo, goe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic       m_conn = 0;
  logic [4:0] m_do = '0, m_oe = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_conn_led dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .sel_done_i(sel_done), .tgt_resp_i(tgt_resp), .arb_win_ll_i(arb_win),
    .bus_free_i(bus_free), .pin_ctl_i(pin_ctl), .autoload_busy_i(busy),
    .sw_do_i(sw_do), .istat_o(istat), .conn_o(conn),
    .gpio_do_o(gdo), .gpio_oe_o(goe)
  );

  function automatic bit f_hw(logic [6:0] c, logic b);
    return c[5] && !c[6] && !b;
  endfunction

  function automatic logic f_next_conn(logic cur, logic s0, logic s1, logic s2, logic clr);
    if (s0 || s1 || s2) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(string ctag);
    chk(ctag, 32'(conn), 32'(m_conn));
    chk("R7", 32'(istat), 32'({4'b0, m_conn, 3'b0}));
    chk(f_hw(pin_ctl, busy) ? "R8" : "R9", 32'({gdo[0], goe[0]}), 32'({m_do[0], m_oe[0]}));
    chk("R10", 32'({gdo[4:1], goe[4:1]}), 32'({m_do[4:1], m_oe[4:1]}));
  endtask

  // drive inputs at negedge, update model, sample just after next posedge
  task automatic step(logic s0, logic s1, logic s2, logic clr,
                      logic [6:0] c, logic b, logic [4:0] d);
    string ctag;
    @(negedge clk);
    sel_done = s0; tgt_resp = s1; arb_win = s2; bus_free = clr;
    pin_ctl = c; busy = b; sw_do = d;
    if (f_hw(c, b)) begin
      m_do[0] = m_conn; m_oe[0] = 1'b1;
    end else begin
      m_do[0] = d[0]; m_oe[0] = c[0];
    end
    m_do[4:1] = d[4:1]; m_oe[4:1] = c[4:1];
    m_conn = f_next_conn(m_conn, s0, s1, s2, clr);
    if (s0) ctag = "R2";
    else if (s1) ctag = "R3";
    else if (s2) ctag = "R4";
    else if (clr) ctag = "R5";
    else ctag = "R6";
    if ((s0 || s1 || s2) && clr) ctag = "R5";
    @(posedge clk); #1;
    check_all(ctag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset state
    pin_ctl = 7'h7f; sw_do = 5'h1f;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", 32'({conn, gdo, goe}), 32'h0);
    chk("R1", 32'(istat), 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // directed: each set source, clear, set-vs-clear collision
    step(1, 0, 0, 0, 7'h20, 0, 5'h00);      // R2, hw mode
    step(0, 0, 0, 0, 7'h20, 0, 5'h00);      // pin0 shows conn
    step(0, 0, 0, 1, 7'h20, 0, 5'h00);      // R5 clear
    step(0, 1, 0, 0, 7'h20, 0, 5'h00);      // R3
    step(0, 0, 0, 1, 7'h20, 0, 5'h00);
    step(0, 0, 1, 0, 7'h20, 0, 5'h00);      // R4
    step(0, 0, 0, 1, 7'h20, 0, 5'h00);
    step(1, 0, 0, 1, 7'h20, 0, 5'h00);      // R5 set wins
    step(0, 1, 1, 1, 7'h20, 0, 5'h00);
    step(0, 0, 0, 0, 7'h20, 0, 5'h00);      // R6 hold
    // R9: each gate condition failing alone, conn=1
    step(0, 0, 0, 0, 7'h60, 0, 5'h00);      // fetch enable set
    step(0, 0, 0, 0, 7'h20, 1, 5'h00);      // autoload busy
    step(0, 0, 0, 0, 7'h00, 0, 5'h01);      // led request off
    step(0, 0, 0, 0, 7'h21, 1, 5'h1e);
    step(0, 0, 0, 0, 7'h3f, 0, 5'h1e);      // R8 back to hw, R10 others
    step(0, 0, 0, 1, 7'h3f, 0, 5'h1f);
    step(0, 0, 0, 0, 7'h3f, 0, 5'h1f);      // pin0 low though sw high

    // random
    for (int i = 0; i < N_RAND; i++) begin
      logic [31:0] r = $urandom;
      logic [6:0] c = 7'($urandom);
      if (r[20:19] != 2'b00) begin c[5] = 1'b1; c[6] = r[21] & r[22]; end
      step(r[3:0] == 4'h0, r[7:4] == 4'h0, r[11:8] == 4'h0, r[14:12] == 3'h0,
           c, r[17:15] == 3'h0, 5'($urandom));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule